// File: doc/BRIEF.md
# Four-Phase Instruction Cycle Sequencer

This block paces a small accumulator processor that uses 14-bit instruction words. It divides the oscillator clock into instruction cycles of four clocks and drives one strobe for each phase. The next word is fetched while the current one executes. At the end of each cycle the fetched word moves into the instruction register and the program counter advances by one.

The execute stage can report four events at the end of a cycle: a taken conditional skip, a computed branch, a call or a goto. Any of these makes the prefetched word stale. The sequencer then marks the next cycle as an invalid, all-zero NOP. During that NOP cycle it fetches from the corrected address. As a result, a taken skip or a program-counter change costs two instruction cycles.

For calls and gotos, the block reads the 11-bit target from the low bits of the instruction register and places an external page value above it. It does not decode the rest of the instruction word.

Top module: `instr_cycle_seq`

## Requirements
- R1: `phaseStrobe` is one-hot and advances 0001→0010→0100→1000→0001, one step per clock. After reset it reads 0001.
- R2: `pcOut`, `irOut` and `irValid` change only on the clock edge that ends phase 3. The execute flags are sampled only at that edge.
- R3: A valid cycle that ends with no flag set does three things: it loads the fetched word into `irOut`, sets `irValid`, and increments `pcOut` by one.
- R4: A taken skip at the end of a valid cycle gives a NOP cycle next (`irValid`=0, `irOut`=0x0000) and increments `pcOut` by one. The prefetched word is therefore never executed.
- R5: A call or goto at the end of a valid cycle loads `pcOut` with `{pageBits, irOut[10:0]}` and gives a NOP cycle next.
- R6: A branch at the end of a valid cycle loads `pcOut` from `branchAddr` and gives a NOP cycle next.
- R7: When several flags are set together, call or goto has highest priority, then branch, then skip.
- R8: All flags are ignored at the end of a NOP cycle. That cycle always ends with a normal load and `pcOut`+1.
- R9: Reset sets `pcOut` to 0, `irValid` to 0 and `irOut` to 0. The first cycle after reset is a NOP that fetches address 0.
- R10: The program counter wraps from its all-ones value to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Oscillator clock |
| rstN | input | 1 | Asynchronous active-low reset |
| fetchWord | input | 14 | Program word read at `pcOut` |
| skipTaken | input | 1 | Execute stage: conditional skip taken |
| branchTaken | input | 1 | Execute stage: computed program-counter write |
| callTaken | input | 1 | Execute stage: call instruction |
| gotoTaken | input | 1 | Execute stage: goto instruction |
| branchAddr | input | 13 | Target for a computed branch |
| pageBits | input | 2 | Page bits placed above call/goto targets |
| phaseStrobe | output | 4 | One-hot phase strobes |
| pcOut | output | 13 | Fetch address |
| irOut | output | 14 | Instruction register |
| irValid | output | 1 | 1 = real instruction, 0 = forced NOP |

## Verification
The assertions check on every cycle that the strobe is one-hot and rotates, and that state stays stable inside a cycle. They also check each end-of-cycle update: increment, flush into a zero NOP, jump target, branch target and recovery after a NOP. The bench scenarios show the rest. These include that a skipped word never reaches the instruction register, that priority holds when flags overlap, and that a flag changed before phase 3 has no effect. They also cover program-counter wrap-around and the NOP fetch at address 0 after reset.

// File: rtl/seq_pkg.sv
`timescale 1ns/1ps
package seq_pkg;
  // Strobes passed from control to datapath each clock
  typedef struct packed {
    logic cycleEnd;    // last phase of the instruction cycle
    logic redirect;    // flush: next cycle becomes a NOP
    logic takeJump;    // call/goto target select
    logic takeBranch;  // computed-branch target select
  } seqCtl_t;
endpackage

// File: rtl/seq_ctrl.sv
`timescale 1ns/1ps
module seq_ctrl
  import seq_pkg::*;
#(
  parameter int PHASES = 4
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              irValid,
  input  logic              skipTaken,
  input  logic              branchTaken,
  input  logic              callTaken,
  input  logic              gotoTaken,
  output logic [PHASES-1:0] phaseStrobe,
  output seqCtl_t           ctl
);
  localparam int PH_W = $clog2(PHASES);
  localparam logic [PH_W-1:0] LAST_PH = PH_W'(PHASES - 1);

  logic [PH_W-1:0] phQ;
  logic jumpReq;
  logic anyReq;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)              phQ <= '0;
    else if (phQ == LAST_PH) phQ <= '0;
    else                    phQ <= phQ + PH_W'(1);
  end

  for (genvar g = 0; g < PHASES; g++) begin : g_strobe
    assign phaseStrobe[g] = (phQ == PH_W'(g));
  end

  always_comb begin
    jumpReq        = callTaken | gotoTaken;
    anyReq         = jumpReq | branchTaken | skipTaken;
    ctl.cycleEnd   = (phQ == LAST_PH);
    ctl.redirect   = ctl.cycleEnd & irValid & anyReq;
    ctl.takeJump   = jumpReq;
    ctl.takeBranch = branchTaken & ~jumpReq;
  end
endmodule

// File: rtl/seq_datapath.sv
`timescale 1ns/1ps
module seq_datapath
  import seq_pkg::*;
#(
  parameter int WORD_W = 14,
  parameter int PC_W   = 13,
  parameter int TGT_W  = 11
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  seqCtl_t               ctl,
  input  logic [WORD_W-1:0]     fetchWord,
  input  logic [PC_W-1:0]       branchAddr,
  input  logic [PC_W-TGT_W-1:0] pageBits,
  output logic [PC_W-1:0]       pcOut,
  output logic [WORD_W-1:0]     irOut,
  output logic                  irValid
);
  logic [PC_W-1:0]   pcQ;
  logic [WORD_W-1:0] irQ;
  logic              validQ;
  logic [PC_W-1:0]   pcInc;
  logic [PC_W-1:0]   redirectPc;

  always_comb begin
    pcInc = pcQ + PC_W'(1);
    if (ctl.takeJump)        redirectPc = {pageBits, irQ[TGT_W-1:0]};
    else if (ctl.takeBranch) redirectPc = branchAddr;
    else                     redirectPc = pcInc;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      pcQ    <= '0;
      irQ    <= '0;
      validQ <= 1'b0;
    end else if (ctl.cycleEnd) begin
      if (ctl.redirect) begin
        pcQ    <= redirectPc;
        irQ    <= '0;
        validQ <= 1'b0;
      end else begin
        pcQ    <= pcInc;
        irQ    <= fetchWord;
        validQ <= 1'b1;
      end
    end
  end

  assign pcOut   = pcQ;
  assign irOut   = irQ;
  assign irValid = validQ;
endmodule

// File: rtl/instr_cycle_seq.sv
`timescale 1ns/1ps
module instr_cycle_seq
  import seq_pkg::*;
#(
  parameter int WORD_W = 14,
  parameter int PC_W   = 13,
  parameter int TGT_W  = 11,
  parameter int PHASES = 4
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  logic [WORD_W-1:0]     fetchWord,
  input  logic                  skipTaken,
  input  logic                  branchTaken,
  input  logic                  callTaken,
  input  logic                  gotoTaken,
  input  logic [PC_W-1:0]       branchAddr,
  input  logic [PC_W-TGT_W-1:0] pageBits,
  output logic [PHASES-1:0]     phaseStrobe,
  output logic [PC_W-1:0]       pcOut,
  output logic [WORD_W-1:0]     irOut,
  output logic                  irValid
);
  seqCtl_t ctl;

  seq_ctrl #(.PHASES(PHASES)) u_ctrl (
    .clk(clk), .rstN(rstN), .irValid(irValid),
    .skipTaken(skipTaken), .branchTaken(branchTaken),
    .callTaken(callTaken), .gotoTaken(gotoTaken),
    .phaseStrobe(phaseStrobe), .ctl(ctl)
  );

  seq_datapath #(.WORD_W(WORD_W), .PC_W(PC_W), .TGT_W(TGT_W)) u_dp (
    .clk(clk), .rstN(rstN), .ctl(ctl), .fetchWord(fetchWord),
    .branchAddr(branchAddr), .pageBits(pageBits),
    .pcOut(pcOut), .irOut(irOut), .irValid(irValid)
  );
endmodule

// File: rtl/seq_checker.sv
`timescale 1ns/1ps
module seq_checker #(
  parameter int WORD_W = 14,
  parameter int PC_W   = 13,
  parameter int TGT_W  = 11,
  parameter int PHASES = 4
) (
  input logic                  clk,
  input logic                  rstN,
  input logic                  skipTaken,
  input logic                  branchTaken,
  input logic                  callTaken,
  input logic                  gotoTaken,
  input logic [PC_W-1:0]       branchAddr,
  input logic [PC_W-TGT_W-1:0] pageBits,
  input logic [PHASES-1:0]     phaseStrobe,
  input logic [PC_W-1:0]       pcOut,
  input logic [WORD_W-1:0]     irOut,
  input logic                  irValid
);
  logic endPh;
  logic anyFlag;
  assign endPh   = phaseStrobe[PHASES-1];
  assign anyFlag = skipTaken | branchTaken | callTaken | gotoTaken;

  AST_STROBE_ONEHOT: assert property (@(posedge clk) disable iff (!rstN)
    $countones(phaseStrobe) == 1); // R1
  AST_STROBE_WRAP: assert property (@(posedge clk) disable iff (!rstN)
    endPh |=> phaseStrobe[0]); // R1
  AST_STROBE_STEP: assert property (@(posedge clk) disable iff (!rstN)
    phaseStrobe[0] |=> phaseStrobe[1]); // R1
  AST_HOLD_MIDCYCLE: assert property (@(posedge clk) disable iff (!rstN)
    !endPh |=> ($stable(pcOut) && $stable(irOut) && $stable(irValid))); // R2
  AST_SEQ_ADVANCE: assert property (@(posedge clk) disable iff (!rstN)
    (endPh && irValid && !anyFlag) |=> (irValid && pcOut == $past(pcOut) + PC_W'(1))); // R3
  AST_SKIP_NOP: assert property (@(posedge clk) disable iff (!rstN)
    (endPh && irValid && anyFlag) |=> (!irValid && irOut == '0)); // R4
  AST_SKIP_PC: assert property (@(posedge clk) disable iff (!rstN)
    (endPh && irValid && skipTaken && !branchTaken && !callTaken && !gotoTaken)
      |=> pcOut == $past(pcOut) + PC_W'(1)); // R4
  AST_JUMP_TARGET: assert property (@(posedge clk) disable iff (!rstN)
    (endPh && irValid && (callTaken || gotoTaken))
      |=> pcOut == {$past(pageBits), $past(irOut[TGT_W-1:0])}); // R5
  AST_BRANCH_TARGET: assert property (@(posedge clk) disable iff (!rstN)
    (endPh && irValid && branchTaken && !callTaken && !gotoTaken)
      |=> pcOut == $past(branchAddr)); // R6
  AST_NOP_RECOVER: assert property (@(posedge clk) disable iff (!rstN)
    (endPh && !irValid) |=> (irValid && pcOut == $past(pcOut) + PC_W'(1))); // R8
endmodule

bind instr_cycle_seq seq_checker #(
  .WORD_W(WORD_W), .PC_W(PC_W), .TGT_W(TGT_W), .PHASES(PHASES)
) u_seq_checker (
  .clk(clk), .rstN(rstN), .skipTaken(skipTaken), .branchTaken(branchTaken),
  .callTaken(callTaken), .gotoTaken(gotoTaken), .branchAddr(branchAddr),
  .pageBits(pageBits), .phaseStrobe(phaseStrobe), .pcOut(pcOut),
  .irOut(irOut), .irValid(irValid)
);

// File: tb/test_instr_cycle_seq.sv
`timescale 1ns/1ps
module test_instr_cycle_seq;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [13:0] fetchWord;
  logic        skipTaken = 1'b0, branchTaken = 1'b0, callTaken = 1'b0, gotoTaken = 1'b0;
  logic [12:0] branchAddr = '0;
  logic [1:0]  pageBits = '0;
  logic [3:0]  phaseStrobe;
  logic [12:0] pcOut;
  logic [13:0] irOut;
  logic        irValid;

  int testsRun = 0;
  int testsFailed = 0;

  always #2.5 clk = ~clk;

  // program memory model: word = {101, addr[10:0] + 0x100}
  function automatic logic [13:0] memWord(input logic [12:0] a);
    logic [10:0] lo;
    lo = a[10:0] + 11'h100;
    return {3'b101, lo};
  endfunction

  assign fetchWord = memWord(pcOut);

  instr_cycle_seq i_instr_cycle_seq (
    .clk(clk), .rstN(rstN), .fetchWord(fetchWord),
    .skipTaken(skipTaken), .branchTaken(branchTaken),
    .callTaken(callTaken), .gotoTaken(gotoTaken),
    .branchAddr(branchAddr), .pageBits(pageBits),
    .phaseStrobe(phaseStrobe), .pcOut(pcOut), .irOut(irOut), .irValid(irValid)
  );

  task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    testsRun++;
    if (!ok) begin
      testsFailed++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  // {skip, branch, call, goto, branchAddr[12:0], page[1:0], expValid, expPc[12:0]}
  localparam int NV = 15;
  localparam logic [32:0] VEC [NV] = '{
    {4'b0000, 13'h0000, 2'd0, 1'b1, 13'h0001},
    {4'b0000, 13'h0000, 2'd0, 1'b1, 13'h0002},
    {4'b1000, 13'h0000, 2'd0, 1'b0, 13'h0003},
    {4'b1000, 13'h0000, 2'd0, 1'b1, 13'h0004},
    {4'b0001, 13'h0000, 2'd1, 1'b0, 13'h0903},
    {4'b0000, 13'h0000, 2'd0, 1'b1, 13'h0904},
    {4'b0100, 13'h1FFE, 2'd0, 1'b0, 13'h1FFE},
    {4'b0000, 13'h0000, 2'd0, 1'b1, 13'h1FFF},
    {4'b0000, 13'h0000, 2'd0, 1'b1, 13'h0000},
    {4'b1110, 13'h0040, 2'd0, 1'b0, 13'h00FF},
    {4'b0000, 13'h0000, 2'd0, 1'b1, 13'h0100},
    {4'b1100, 13'h0040, 2'd0, 1'b0, 13'h0040},
    {4'b0000, 13'h0000, 2'd0, 1'b1, 13'h0041},
    {4'b1000, 13'h0000, 2'd0, 1'b0, 13'h0042},
    {4'b0000, 13'h0000, 2'd0, 1'b1, 13'h0043}
  };
  localparam string TAGS [NV] = '{"R9", "R3", "R4", "R8", "R5", "R8", "R6", "R3",
                                   "R10", "R7", "R5", "R7", "R6", "R4", "R4"};

  task automatic oneCycle();
    repeat (4) @(posedge clk);
    @(negedge clk);
  endtask

  initial begin : watchdog
    #1000000;
    testsRun++;
    testsFailed++;
    $display("FAIL watchdog expired");
    $display("[TB] %0d tests run, %0d failed", testsRun, testsFailed);
    $finish;
  end

  initial begin : main
    logic [12:0] pcHold;
    logic [13:0] expIr;
    repeat (3) @(negedge clk);
    // R9 reset state
    check(phaseStrobe == 4'b0001, "R1 reset strobe", 32'(phaseStrobe), 32'h1);
    check(pcOut == '0, "R9 reset pc", 32'(pcOut), 32'h0);
    check(!irValid && irOut == '0, "R9 reset ir", 32'({irValid, irOut}), 32'h0);
    rstN = 1'b1;

    for (int i = 0; i < NV; i++) begin
      {skipTaken, branchTaken, callTaken, gotoTaken} = VEC[i][32:29];
      branchAddr = VEC[i][28:16];
      pageBits   = VEC[i][15:14];
      oneCycle();
      expIr = VEC[i][13] ? memWord(VEC[i][12:0] - 13'd1) : 14'h0;
      check(irValid == VEC[i][13], {TAGS[i], " valid"}, 32'(irValid), 32'(VEC[i][13]));
      check(pcOut == VEC[i][12:0], {TAGS[i], " pc"}, 32'(pcOut), 32'(VEC[i][12:0]));
      check(irOut == expIr, {TAGS[i], " ir"}, 32'(irOut), 32'(expIr));
    end
    {skipTaken, branchTaken, callTaken, gotoTaken} = 4'b0000;

    // R1 rotation and R2 mid-cycle hold
    pcHold = pcOut;
    for (int k = 0; k < 8; k++) begin
      check(phaseStrobe == 4'(1 << (k % 4)), "R1 rotate", 32'(phaseStrobe), 32'(1 << (k % 4)));
      if (k % 4 != 0) check(pcOut == pcHold, "R2 hold", 32'(pcOut), 32'(pcHold));
      else pcHold = pcOut;
      @(posedge clk); @(negedge clk);
    end

    // R2: flag dropped before the last phase has no effect
    skipTaken = 1'b1;
    repeat (3) begin @(posedge clk); @(negedge clk); end
    skipTaken = 1'b0;
    @(posedge clk); @(negedge clk);
    check(irValid == 1'b1, "R2 early flag ignored", 32'(irValid), 32'h1);
    // R2: flag raised only in the last phase is honoured
    repeat (3) begin @(posedge clk); @(negedge clk); end
    pcHold = pcOut;
    skipTaken = 1'b1;
    @(posedge clk); @(negedge clk);
    skipTaken = 1'b0;
    check(irValid == 1'b0, "R2 late flag flush", 32'(irValid), 32'h0);
    check(pcOut == pcHold + 13'd1, "R4 late skip pc", 32'(pcOut), 32'(pcHold + 13'd1));

    // R9: reset in mid-cycle, then a NOP fetching address 0
    @(posedge clk); @(negedge clk);
    rstN = 1'b0;
    @(negedge clk);
    check(phaseStrobe == 4'b0001 && pcOut == '0 && !irValid, "R9 mid reset",
          32'({phaseStrobe, pcOut, irValid}), 32'({4'b0001, 13'h0, 1'b0}));
    rstN = 1'b1;
    oneCycle();
    check(irValid && irOut == memWord(13'h0) && pcOut == 13'h1, "R9 first word",
          32'({irValid, irOut}), 32'({1'b1, memWord(13'h0)}));

    $display("[TB] %0d tests run, %0d failed", testsRun, testsFailed);
    $finish;
  end
endmodule